// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor 24 general I/O lines, arranged as three 8-bit ports (A, B, C), reached through four bus registers. A single control register does two jobs chosen by its top bit. One form picks the operating mode of each port group and the direction of every port. The other form sets or clears a single port C bit without touching the configuration.

Port C is split into two 4-bit halves, and each half has its own direction. In strobed mode some port C lines become handshake lines. Port A then captures data on an external strobe. Port B then tells a peripheral that output data is pending and waits for its acknowledge. Each peripheral pin has its own input, output and output-enable bit, so the pads can sit outside the block.

The bus side is a plain register interface with single-cycle strobes and no back-pressure. A write takes effect on the clock edge that samples it. A read returns data in the same cycle as the read strobe, and any side effect of the read follows at that edge. The handshake inputs are assumed to be synchronous to `clk`.

Top module: `pario_ctl`

## Requirements
- R1: `bus_addr` selects port A (00), port B (01), port C (10) or control (11). A write has effect only when `bus_cs` and `bus_wr` are high. `bus_rdata` carries data only when `bus_cs` and `bus_rd` are high, and is 0 otherwise. The control register reads as 0.
- R2: After reset all ports are inputs in basic mode, every `*_oe` bit is 0 and every output latch is 0.
- R3: A control write with bit 7 = 1 sets up the mode. Bits 6:5 give the group A mode (01 = strobed). Bit 4 gives the port A direction, bit 3 the port C upper-half direction, bit 2 the group B mode (1 = strobed), bit 1 the port B direction and bit 0 the port C lower-half direction. A direction bit of 1 means input. In basic mode an output port drives its latch with all enable bits set.
- R4: A mode-setting write clears the A, B and C output latches and the handshake flags (IBF = 0, both interrupts = 0, OBF_n = 1).
- R5: A control write with bit 7 = 0 writes bit 0 into the port C latch bit indexed by bits 3:1. Mode and directions stay unchanged.
- R6: In basic mode a read of an input port or input half returns the live pins. A read of an output port or output half returns its latch.
- R7: A group A mode field of 10 or 11 behaves as basic mode.
- R8: When group A is strobed, port A is an input. On the first cycle in which `pc_in[4]` is sampled low after being high, the port A pins are held. IBF (`pc_out[5]`) becomes 1, and the interrupt (`pc_out[3]`) takes the value of the port C latch bit 4.
- R9: When group A is strobed, a port A read returns the held value. At the end of that read cycle IBF and the port A interrupt return to 0.
- R10: When group B is strobed, port B drives its latch on every pin. A port B write sets OBF_n (`pc_out[1]`) to 0 and clears the interrupt (`pc_out[0]`). The first cycle with `pc_in[2]` sampled low after high sets OBF_n to 1 and sets the interrupt to the port C latch bit 2. If a write and an acknowledge arrive in the same cycle, the write wins.
- R11: A port C read in strobed mode returns status on the handshake bits: bit 5 IBF, bit 4 latch bit 4, bit 3 port A interrupt (group A), and bit 2 latch bit 2, bit 1 OBF_n, bit 0 port B interrupt (group B). The other bits follow R6.
- R12: Handshake outputs (PC3 and PC5 for group A, PC0 and PC1 for group B) are enabled. Handshake inputs (PC4, PC2) are not enabled. The remaining port C bits follow their half's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin outputs |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin outputs |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C pin outputs |
| pc_oe | output | 8 | Port C output enables |

## Verification
A corrupted configuration shows on the `*_oe` vectors on the cycle after the control write, since every enable bit is decoded directly from stored state. A wrong handshake flag appears on `pc_out` one cycle after the strobe, acknowledge, read or write that should have moved it, and again in the next port C read. A held value captured on the wrong edge can only be seen at the next port A read. The bench therefore changes the pins after each strobe, so that a live pin value cannot pass for the held one.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int PW = 8;
  localparam int SELW = 2;

  typedef enum logic [SELW-1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  typedef struct packed {
    logic a_strobed;
    logic b_strobed;
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } cfg_t;

  // port C roles when the owning group runs strobed
  localparam int C_INTR_B = 0;
  localparam int C_OBF_B  = 1;
  localparam int C_ACK_B  = 2;
  localparam int C_INTR_A = 3;
  localparam int C_STB_A  = 4;
  localparam int C_IBF_A  = 5;
  localparam int HALF     = PW / 2;
endpackage

// File: rtl/pario_cfg.sv
module pario_cfg
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          c_wr,
  input  logic [PW-1:0] wdata,
  output cfg_t          cfg,
  output logic [PW-1:0] c_latch
);
  localparam int IDXW = $clog2(PW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '{a_strobed: 1'b0, b_strobed: 1'b0, a_in: 1'b1,
                   b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
      c_latch <= '0;
    end else if (ctl_wr && wdata[7]) begin
      cfg.a_strobed <= (wdata[6:5] == 2'b01);
      cfg.a_in      <= wdata[4];
      cfg.cu_in     <= wdata[3];
      cfg.b_strobed <= wdata[2];
      cfg.b_in      <= wdata[1];
      cfg.cl_in     <= wdata[0];
      c_latch       <= '0;
    end else if (ctl_wr) begin
      c_latch[wdata[IDXW:1]] <= wdata[0];
    end else if (c_wr) begin
      c_latch <= wdata;
    end
  end

  a_r4_c_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7]) |=> (c_latch == '0));
  a_r5_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[7]) |=> $stable(cfg));
endmodule

// File: rtl/pario_hs_in.sv
module pario_hs_in
  import pario_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          stb_n,
  input  logic          inte,
  input  logic          rd_evt,
  input  logic [PW-1:0] pins,
  output logic [PW-1:0] hold,
  output logic          ibf,
  output logic          intr
);
  logic stb_q;
  logic fall;
  assign fall = en && stb_q && !stb_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b1;
      hold  <= '0;
      ibf   <= 1'b0;
      intr  <= 1'b0;
    end else begin
      stb_q <= stb_n;
      if (clr) begin
        ibf  <= 1'b0;
        intr <= 1'b0;
      end else if (fall) begin
        hold <= pins;
        ibf  <= 1'b1;
        intr <= inte;
      end else if (rd_evt && en) begin
        ibf  <= 1'b0;
        intr <= 1'b0;
      end
    end
  end

  a_r8_ibf_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && $fell(stb_n)) |=> ibf);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_evt && !clr && !$fell(stb_n)) |=> (!ibf && !intr));
endmodule

// File: rtl/pario_hs_out.sv
module pario_hs_out
  import pario_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic ack_n,
  input  logic inte,
  input  logic wr_evt,
  output logic obf_n,
  output logic intr
);
  logic ack_q;
  logic ack_fall;
  assign ack_fall = en && ack_q && !ack_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b1;
      obf_n <= 1'b1;
      intr  <= 1'b0;
    end else begin
      ack_q <= ack_n;
      if (clr) begin
        obf_n <= 1'b1;
        intr  <= 1'b0;
      end else if (wr_evt && en) begin
        obf_n <= 1'b0;
        intr  <= 1'b0;
      end else if (ack_fall) begin
        obf_n <= 1'b1;
        intr  <= inte;
      end
    end
  end

  a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_evt && !clr) |=> (!obf_n && !intr));
  a_r10_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_evt && !clr && $fell(ack_n)) |=> obf_n);
endmodule

// File: rtl/pario_ctl.sv
module pario_ctl
  import pario_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_cs,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  sel_e sel;
  assign sel = sel_e'(bus_addr);

  logic wr_a, wr_b, wr_c, wr_ctl, rd_a, mode_load;
  assign wr_a      = bus_cs && bus_wr && (sel == SEL_A);
  assign wr_b      = bus_cs && bus_wr && (sel == SEL_B);
  assign wr_c      = bus_cs && bus_wr && (sel == SEL_C);
  assign wr_ctl    = bus_cs && bus_wr && (sel == SEL_CTL);
  assign rd_a      = bus_cs && bus_rd && (sel == SEL_A);
  assign mode_load = wr_ctl && bus_wdata[7];

  cfg_t cfg;
  logic [PW-1:0] c_latch, a_latch, b_latch, a_hold;
  logic ibf_a, intr_a, obf_b_n, intr_b;

  pario_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wr_ctl), .c_wr(wr_c),
    .wdata(bus_wdata), .cfg(cfg), .c_latch(c_latch)
  );

  pario_hs_in u_hs_a (
    .clk(clk), .rst_n(rst_n), .en(cfg.a_strobed), .clr(mode_load),
    .stb_n(pc_in[C_STB_A]), .inte(c_latch[C_STB_A]), .rd_evt(rd_a),
    .pins(pa_in), .hold(a_hold), .ibf(ibf_a), .intr(intr_a)
  );

  pario_hs_out u_hs_b (
    .clk(clk), .rst_n(rst_n), .en(cfg.b_strobed), .clr(mode_load),
    .ack_n(pc_in[C_ACK_B]), .inte(c_latch[C_ACK_B]), .wr_evt(wr_b),
    .obf_n(obf_b_n), .intr(intr_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_latch <= '0;
      b_latch <= '0;
    end else if (mode_load) begin
      a_latch <= '0;
      b_latch <= '0;
    end else begin
      if (wr_a) a_latch <= bus_wdata;
      if (wr_b) b_latch <= bus_wdata;
    end
  end

  logic a_drive, b_drive;
  assign a_drive = !cfg.a_strobed && !cfg.a_in;
  assign b_drive = cfg.b_strobed || !cfg.b_in;
  assign pa_out  = a_latch;
  assign pa_oe   = {PW{a_drive}};
  assign pb_out  = b_latch;
  assign pb_oe   = {PW{b_drive}};

  // handshake ownership, drive value, enable and read status of port C
  logic [PW-1:0] own, hs_val, hs_oe, hs_stat, c_rd;
  always_comb begin
    own = '0; hs_val = '0; hs_oe = '0; hs_stat = '0;
    if (cfg.a_strobed) begin
      own[C_INTR_A] = 1'b1; own[C_STB_A] = 1'b1; own[C_IBF_A] = 1'b1;
      hs_val[C_INTR_A] = intr_a; hs_val[C_IBF_A] = ibf_a;
      hs_oe[C_INTR_A] = 1'b1;    hs_oe[C_IBF_A] = 1'b1;
      hs_stat[C_INTR_A] = intr_a; hs_stat[C_IBF_A] = ibf_a;
      hs_stat[C_STB_A] = c_latch[C_STB_A];
    end
    if (cfg.b_strobed) begin
      own[C_INTR_B] = 1'b1; own[C_OBF_B] = 1'b1; own[C_ACK_B] = 1'b1;
      hs_val[C_INTR_B] = intr_b; hs_val[C_OBF_B] = obf_b_n;
      hs_oe[C_INTR_B] = 1'b1;    hs_oe[C_OBF_B] = 1'b1;
      hs_stat[C_INTR_B] = intr_b; hs_stat[C_OBF_B] = obf_b_n;
      hs_stat[C_ACK_B] = c_latch[C_ACK_B];
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_pc
    logic gp_in;
    assign gp_in     = (i >= HALF) ? cfg.cu_in : cfg.cl_in;
    assign pc_out[i] = own[i] ? hs_val[i] : c_latch[i];
    assign pc_oe[i]  = own[i] ? hs_oe[i]  : !gp_in;
    assign c_rd[i]   = own[i] ? hs_stat[i] : (gp_in ? pc_in[i] : c_latch[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_cs && bus_rd) begin
      case (sel)
        SEL_A:   bus_rdata = cfg.a_strobed ? a_hold : (cfg.a_in ? pa_in : a_latch);
        SEL_B:   bus_rdata = b_drive ? b_latch : pb_in;
        SEL_C:   bus_rdata = c_rd;
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r4_ab_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (pa_out == '0 && pb_out == '0));
  a_r1_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |=> ($stable(pa_out) && $stable(pb_out)));
  a_r12_strobe_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_strobed |-> !pc_oe[C_STB_A]) and (cfg.b_strobed |-> !pc_oe[C_ACK_B]));
endmodule

// File: tb/pario_ctl_bench.sv
module pario_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'h96, pb_in = 8'h5C, pc_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pario_ctl u_pario_ctl (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk);
    bus_cs = cs; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic pulse_c(input int bitn);
    @(negedge clk); pc_in[bitn] = 1'b0;
    @(negedge clk); pc_in[bitn] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check8("R2 pa_oe", pa_oe, 8'h00);
    check8("R2 pb_oe", pb_oe, 8'h00);
    check8("R2 pc_oe", pc_oe, 8'h00);
    check8("R2 pa_out", pa_out, 8'h00);
    rd(2'b00, d); check8("R2 read A pins", d, 8'h96);
    rd(2'b10, d); check8("R2 read C pins", d, 8'hFF);
    #1 check8("R1 idle rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] d;
    wr(2'b11, 8'h80);
    check8("R3 pa_oe out", pa_oe, 8'hFF);
    check8("R3 pc_oe out", pc_oe, 8'hFF);
    wr(2'b00, 8'h5A); wr(2'b01, 8'hC3);
    check8("R3 pa_out", pa_out, 8'h5A);
    check8("R3 pb_out", pb_out, 8'hC3);
    wr(2'b00, 8'h11, 1'b0);
    check8("R1 no cs write", pa_out, 8'h5A);
    rd(2'b00, d); check8("R6 read A latch", d, 8'h5A);
    rd(2'b11, d); check8("R1 control reads 0", d, 8'h00);
    wr(2'b11, 8'h88);
    check8("R4 A cleared", pa_out, 8'h00);
    check8("R4 B cleared", pb_out, 8'h00);
    check8("R3 pc_oe halves", pc_oe, 8'h0F);
    wr(2'b10, 8'hA5);
    rd(2'b10, d); check8("R6 read C mixed", d, 8'hF5);
  endtask

  task automatic t_bitset;
    wr(2'b11, 8'h0E);
    check8("R5 clear bit7", pc_out, 8'h25);
    check8("R5 cfg kept", pc_oe, 8'h0F);
    wr(2'b11, 8'h00);
    check8("R5 clear bit0", pc_out, 8'h24);
    wr(2'b11, 8'h07);
    check8("R5 set bit3", pc_out, 8'h2C);
  endtask

  task automatic t_inputs;
    logic [7:0] d;
    wr(2'b11, 8'h92);
    pa_in = 8'h21; pb_in = 8'h43;
    rd(2'b00, d); check8("R6 A live", d, 8'h21);
    rd(2'b01, d); check8("R6 B live", d, 8'h43);
    pa_in = 8'h22;
    rd(2'b00, d); check8("R6 A follows pins", d, 8'h22);
  endtask

  task automatic t_fallback;
    logic [7:0] d;
    wr(2'b11, 8'hD0);
    check8("R7 pa_oe", pa_oe, 8'h00);
    check8("R7 pc_oe all", pc_oe, 8'hFF);
    pa_in = 8'h3F;
    pulse_c(4);
    check8("R7 no handshake", pc_out, 8'h00);
    pa_in = 8'h40;
    rd(2'b00, d); check8("R7 A live", d, 8'h40);
  endtask

  task automatic t_strobe_in;
    logic [7:0] d;
    wr(2'b11, 8'hB0);
    check8("R12 pc_oe A strobed", pc_oe, 8'hEF);
    check8("R8 pa_oe off", pa_oe, 8'h00);
    wr(2'b11, 8'h09);
    pa_in = 8'h3C;
    pulse_c(4);
    check8("R8 IBF/INTR", pc_out & 8'h28, 8'h28);
    pa_in = 8'h00;
    rd(2'b10, d); check8("R11 C status A", d, 8'h38);
    rd(2'b00, d); check8("R9 held value", d, 8'h3C);
    check8("R9 flags cleared", pc_out & 8'h28, 8'h00);
    wr(2'b11, 8'h08);
    pa_in = 8'h71;
    pulse_c(4);
    check8("R8 INTR gated", pc_out & 8'h28, 8'h20);
    pa_in = 8'h00;
    rd(2'b00, d); check8("R9 held value 2", d, 8'h71);
  endtask

  task automatic t_strobe_out;
    logic [7:0] d;
    wr(2'b11, 8'h84);
    check8("R12 pc_oe B strobed", pc_oe, 8'hFB);
    check8("R10 pb_oe", pb_oe, 8'hFF);
    check8("R4 OBF idle", pc_out & 8'h03, 8'h02);
    wr(2'b11, 8'h05);
    wr(2'b01, 8'h77);
    check8("R10 pb_out", pb_out, 8'h77);
    check8("R10 OBF low", pc_out & 8'h03, 8'h00);
    pulse_c(2);
    check8("R10 ack", pc_out & 8'h03, 8'h03);
    rd(2'b10, d); check8("R11 C status B", d, 8'h07);
    rd(2'b01, d); check8("R10 read B latch", d, 8'h77);
    wr(2'b01, 8'h12);
    check8("R10 rewrite", pc_out & 8'h03, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bitset();
    t_inputs();
    t_fallback();
    t_strobe_in();
    t_strobe_out();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule